// File: doc/BRIEF.md
# Boot Mode Latch and Control Register

This block fixes the operating mode of a processor subsystem from two strap pins. While reset is held it samples both pins on every clock. When reset is released, the last sampled values stay in an 8-bit control register. Two bits of that register, the special flag and the select-A flag, give one of four modes: single-chip, expanded, bootstrap or special test.

The same register holds a bootstrap-ROM map enable, an internal-read-visibility enable and a 4-bit priority-select field. A downstream interrupt controller uses the priority-select field. Each bit has its own write permission, and that permission depends on the mode. The special flag can be cleared but never set again. In the normal modes the visibility bit accepts only the first write after reset.

From the register the block drives the following outputs:
- the upper byte of the reset-vector region;
- the bootstrap-ROM map enable;
- a hit signal for the ROM's 256-byte page;
- a gated read-visibility enable.

Software reaches the register through a single select line, a write strobe and 8-bit data. A write takes effect on the rising clock edge at which both the select and the strobe are high.

Top module: `opmode_ctl`

## Requirements
- R1: While rst_n is low, each clock edge loads the register from the pins. After release it reads back with bit layout [7]=ROM map, [6]=special, [5]=select-A, [4]=visibility, [3:0]=priority. The reset values are: special = NOT strap_b, select-A = strap_a, visibility = 0, priority = 4'b0101, and ROM map = 1 only when both pins are 0.
- R2: op_mode equals {special, select-A}. The encodings are 2'b00 single-chip, 2'b01 expanded, 2'b10 bootstrap and 2'b11 special test.
- R3: vec_hi is 8'hBF while special = 1 and 8'hFF while special = 0.
- R4: boot_rom_en equals the ROM map bit. boot_rom_hit is 1 exactly when the ROM map bit is 1 and addr_hi equals 8'hBF.
- R5: Bits 7, 6 and 5 take written data only when special = 1 before the write. In the normal modes (special = 0) writes leave them unchanged.
- R6: Once special is 0, it stays 0 until the next reset, whatever is written.
- R7: While special = 1, the visibility bit takes every write. While special = 0, it takes only the first write after reset that happens with special = 0. Later writes leave it unchanged.
- R8: read_vis is 1 exactly when visibility = 1 and the mode is expanded or special test (select-A = 1). It is 0 in single-chip and bootstrap modes.
- R9: The priority field [3:0] takes written data in every mode.
- R10: The register changes only on a clock edge at which reg_sel and reg_wr are both 1. reg_rdata always shows all eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the pins are captured while it is low |
| strap_a | input | 1 | Mode pin copied into select-A |
| strap_b | input | 1 | Mode pin whose inverse goes into special |
| reg_sel | input | 1 | Register address match |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register contents |
| addr_hi | input | 8 | Upper byte of the CPU address |
| op_mode | output | 2 | Decoded operating mode |
| vec_hi | output | 8 | Upper byte of the reset-vector region |
| boot_rom_en | output | 1 | Bootstrap ROM mapped |
| boot_rom_hit | output | 1 | Address falls in the mapped ROM page |
| read_vis | output | 1 | Internal read visibility active |

## Verification
On every cycle the assertions check the following:
- op_mode, vec_hi, boot_rom_en and read_vis agree with the register bits;
- the register holds its value when there is no write;
- the upper three bits stay frozen in the normal modes;
- the special flag never comes back once it is cleared;
- every write lands in the priority field.

Only the bench scenarios can show the rest. This covers the pin capture for each of the four strap combinations and the exact reset images. It also covers the one-shot visibility write after a mode change from special to normal, which depends on the order of the writes. Last, it covers the page hit at the boundary addresses.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'b00,
      MODE_EXPAND = 2'b01,
      MODE_BOOT   = 2'b10,
      MODE_TEST   = 2'b11
   } opmode_e;

   // Number of fixed control flags above the priority field
   localparam int unsigned FLAG_BITS = 4;

   // Flag offsets counted down from the register MSB
   localparam int unsigned OFS_ROM = 0;
   localparam int unsigned OFS_SPC = 1;
   localparam int unsigned OFS_MSA = 2;
   localparam int unsigned OFS_VIS = 3;

endpackage

// File: rtl/opmode_strap.sv
module opmode_strap
   import opmode_pkg::*;
#(
   parameter int unsigned PRIO_W   = 4,
   parameter logic [PRIO_W-1:0] PRIO_RST = 4'b0101,
   localparam int unsigned DATA_W  = FLAG_BITS + PRIO_W
) (
   input  logic              strap_a,
   input  logic              strap_b,
   output logic [DATA_W-1:0] rst_img
);

   localparam int unsigned B_ROM = DATA_W - 1 - OFS_ROM;
   localparam int unsigned B_SPC = DATA_W - 1 - OFS_SPC;
   localparam int unsigned B_MSA = DATA_W - 1 - OFS_MSA;
   localparam int unsigned B_VIS = DATA_W - 1 - OFS_VIS;

   always_comb begin
      rst_img               = '0;
      rst_img[B_SPC]        = ~strap_b;
      rst_img[B_MSA]        = strap_a;
      rst_img[B_ROM]        = ~strap_b & ~strap_a;
      rst_img[B_VIS]        = 1'b0;
      rst_img[PRIO_W-1:0]   = PRIO_RST;
   end

endmodule

// File: rtl/opmode_regfile.sv
module opmode_regfile
   import opmode_pkg::*;
#(
   parameter int unsigned PRIO_W  = 4,
   localparam int unsigned DATA_W = FLAG_BITS + PRIO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rst_img,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   localparam int unsigned B_SPC = DATA_W - 1 - OFS_SPC;
   localparam int unsigned B_VIS = DATA_W - 1 - OFS_VIS;

   logic              vis_done;
   logic [DATA_W-1:0] wmask;

   // Per-bit write permission chosen by bit class
   for (genvar i = 0; i < DATA_W; i++) begin : g_perm
      if (i > int'(B_VIS)) begin : g_flag
         assign wmask[i] = wr & q[B_SPC];
      end else if (i == int'(B_VIS)) begin : g_vis
         assign wmask[i] = wr & (q[B_SPC] | ~vis_done);
      end else begin : g_prio
         assign wmask[i] = wr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= rst_img;
      end else begin
         q <= (q & ~wmask) | (wdata & wmask);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vis_done <= 1'b0;
      end else if (wr && !q[B_SPC]) begin
         vis_done <= 1'b1;
      end
   end

endmodule

// File: rtl/opmode_decode.sv
module opmode_decode
   import opmode_pkg::*;
#(
   parameter int unsigned PAGE_W       = 8,
   parameter logic [PAGE_W-1:0] ROM_PAGE = 8'hBF,
   parameter logic [PAGE_W-1:0] VEC_NORM = 8'hFF,
   parameter logic [PAGE_W-1:0] VEC_SPEC = 8'hBF
) (
   input  logic              f_rom,
   input  logic              f_spc,
   input  logic              f_msa,
   input  logic              f_vis,
   input  logic [PAGE_W-1:0] addr_hi,
   output opmode_e           mode,
   output logic [PAGE_W-1:0] vec_hi,
   output logic              rom_en,
   output logic              rom_hit,
   output logic              vis_en
);

   always_comb begin
      mode    = opmode_e'({f_spc, f_msa});
      vec_hi  = f_spc ? VEC_SPEC : VEC_NORM;
      rom_en  = f_rom;
      rom_hit = f_rom && (addr_hi == ROM_PAGE);
      vis_en  = f_vis && (mode == MODE_EXPAND || mode == MODE_TEST);
   end

endmodule

// File: rtl/opmode_ctl.sv
module opmode_ctl
   import opmode_pkg::*;
#(
   parameter int unsigned PRIO_W         = 4,
   parameter logic [PRIO_W-1:0] PRIO_RST = 4'b0101,
   parameter int unsigned PAGE_W         = 8,
   parameter logic [PAGE_W-1:0] ROM_PAGE = 8'hBF,
   parameter logic [PAGE_W-1:0] VEC_NORM = 8'hFF,
   parameter logic [PAGE_W-1:0] VEC_SPEC = 8'hBF,
   localparam int unsigned DATA_W        = FLAG_BITS + PRIO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_a,
   input  logic              strap_b,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [PAGE_W-1:0] addr_hi,
   output logic [1:0]        op_mode,
   output logic [PAGE_W-1:0] vec_hi,
   output logic              boot_rom_en,
   output logic              boot_rom_hit,
   output logic              read_vis
);

   localparam int unsigned B_ROM = DATA_W - 1 - OFS_ROM;
   localparam int unsigned B_SPC = DATA_W - 1 - OFS_SPC;
   localparam int unsigned B_MSA = DATA_W - 1 - OFS_MSA;
   localparam int unsigned B_VIS = DATA_W - 1 - OFS_VIS;

   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("opmode_ctl: PRIO_W out of range");
   end
   if (PAGE_W < 1 || PAGE_W > 16) begin : g_bad_page
      $error("opmode_ctl: PAGE_W out of range");
   end

   logic [DATA_W-1:0] rst_img;
   logic [DATA_W-1:0] q;
   opmode_e           mode;

   opmode_strap #(.PRIO_W(PRIO_W), .PRIO_RST(PRIO_RST)) u_strap (
      .strap_a (strap_a),
      .strap_b (strap_b),
      .rst_img (rst_img)
   );

   opmode_regfile #(.PRIO_W(PRIO_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .rst_img (rst_img),
      .wr      (reg_sel & reg_wr),
      .wdata   (reg_wdata),
      .q       (q)
   );

   opmode_decode #(
      .PAGE_W   (PAGE_W),
      .ROM_PAGE (ROM_PAGE),
      .VEC_NORM (VEC_NORM),
      .VEC_SPEC (VEC_SPEC)
   ) u_dec (
      .f_rom   (q[B_ROM]),
      .f_spc   (q[B_SPC]),
      .f_msa   (q[B_MSA]),
      .f_vis   (q[B_VIS]),
      .addr_hi (addr_hi),
      .mode    (mode),
      .vec_hi  (vec_hi),
      .rom_en  (boot_rom_en),
      .rom_hit (boot_rom_hit),
      .vis_en  (read_vis)
   );

   assign op_mode   = mode;
   assign reg_rdata = q;

endmodule

// File: rtl/opmode_ctl_chk.sv
module opmode_ctl_chk #(
   parameter int unsigned PRIO_W         = 4,
   parameter int unsigned PAGE_W         = 8,
   parameter logic [PAGE_W-1:0] VEC_NORM = 8'hFF,
   parameter logic [PAGE_W-1:0] VEC_SPEC = 8'hBF,
   localparam int unsigned DATA_W        = 4 + PRIO_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_sel,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [1:0]        op_mode,
   input logic [PAGE_W-1:0] vec_hi,
   input logic              boot_rom_en,
   input logic              boot_rom_hit,
   input logic              read_vis
);

   localparam int unsigned B_ROM = DATA_W - 1;
   localparam int unsigned B_SPC = DATA_W - 2;
   localparam int unsigned B_MSA = DATA_W - 3;
   localparam int unsigned B_VIS = DATA_W - 4;

   // R2
   mode_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_mode == {reg_rdata[B_SPC], reg_rdata[B_MSA]});

   // R3
   vec_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[B_SPC] |-> vec_hi == VEC_SPEC);

   // R3
   vec_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[B_SPC] |-> vec_hi == VEC_NORM);

   // R4
   rom_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_rom_en == reg_rdata[B_ROM]);

   // R4
   rom_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_rom_hit |-> boot_rom_en);

   // R5
   flag_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[B_SPC] |=> $stable(reg_rdata[B_ROM:B_MSA]));

   // R6
   spc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[B_SPC] |=> !reg_rdata[B_SPC]);

   // R8
   vis_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      read_vis |-> (reg_rdata[B_VIS] && reg_rdata[B_MSA]));

   // R9
   prio_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && reg_wr) |=> reg_rdata[PRIO_W-1:0] == $past(reg_wdata[PRIO_W-1:0]));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_sel && reg_wr) |=> $stable(reg_rdata));

endmodule

bind opmode_ctl opmode_ctl_chk #(
   .PRIO_W   (PRIO_W),
   .PAGE_W   (PAGE_W),
   .VEC_NORM (VEC_NORM),
   .VEC_SPEC (VEC_SPEC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_sel      (reg_sel),
   .reg_wr       (reg_wr),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .op_mode      (op_mode),
   .vec_hi       (vec_hi),
   .boot_rom_en  (boot_rom_en),
   .boot_rom_hit (boot_rom_hit),
   .read_vis     (read_vis)
);

// File: tb/tb_opmode_ctl.sv
module tb_opmode_ctl;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap_a = 1'b0;
   logic       strap_b = 1'b0;
   logic       reg_sel = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [7:0] addr_hi = 8'h00;
   logic [1:0] op_mode;
   logic [7:0] vec_hi;
   logic       boot_rom_en;
   logic       boot_rom_hit;
   logic       read_vis;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opmode_ctl dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .strap_a      (strap_a),
      .strap_b      (strap_b),
      .reg_sel      (reg_sel),
      .reg_wr       (reg_wr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .addr_hi      (addr_hi),
      .op_mode      (op_mode),
      .vec_hi       (vec_hi),
      .boot_rom_en  (boot_rom_en),
      .boot_rom_hit (boot_rom_hit),
      .read_vis     (read_vis)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic b, input logic a);
      @(negedge clk);
      rst_n = 1'b0; strap_b = b; strap_a = a;
      reg_sel = 1'b0; reg_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [7:0] d);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic t_reset_images();
      do_reset(1'b1, 1'b0);
      chk("R1 single image", reg_rdata, 8'h05);
      chk("R2 single mode", {6'd0, op_mode}, 8'h00);
      chk("R3 single vec", vec_hi, 8'hFF);
      chk("R4 single rom_en", {7'd0, boot_rom_en}, 8'h00);
      do_reset(1'b1, 1'b1);
      chk("R1 expanded image", reg_rdata, 8'h25);
      chk("R2 expanded mode", {6'd0, op_mode}, 8'h01);
      do_reset(1'b0, 1'b0);
      chk("R1 bootstrap image", reg_rdata, 8'hC5);
      chk("R2 bootstrap mode", {6'd0, op_mode}, 8'h02);
      chk("R3 bootstrap vec", vec_hi, 8'hBF);
      chk("R4 bootstrap rom_en", {7'd0, boot_rom_en}, 8'h01);
      do_reset(1'b0, 1'b1);
      chk("R1 test image", reg_rdata, 8'h65);
      chk("R2 test mode", {6'd0, op_mode}, 8'h03);
      chk("R8 test vis off after reset", {7'd0, read_vis}, 8'h00);
   endtask

   task automatic t_boot_rom();
      do_reset(1'b0, 1'b0);
      addr_hi = 8'hBF; #1;
      chk("R4 hit in page", {7'd0, boot_rom_hit}, 8'h01);
      addr_hi = 8'hBE; #1;
      chk("R4 below page", {7'd0, boot_rom_hit}, 8'h00);
      addr_hi = 8'hC0; #1;
      chk("R4 above page", {7'd0, boot_rom_hit}, 8'h00);
      addr_hi = 8'hBF;
      wr_reg(8'h45);
      chk("R5 special clears rom map", reg_rdata, 8'h45);
      chk("R4 unmapped no hit", {7'd0, boot_rom_hit}, 8'h00);
      chk("R4 unmapped rom_en", {7'd0, boot_rom_en}, 8'h00);
   endtask

   task automatic t_leave_special();
      do_reset(1'b0, 1'b1);
      wr_reg(8'h1A);
      chk("R5 special write all bits", reg_rdata, 8'h1A);
      chk("R3 vec after leaving special", vec_hi, 8'hFF);
      wr_reg(8'h70);
      chk("R6 special not re-set, R7 first normal vis write", reg_rdata, 8'h10);
      wr_reg(8'h00);
      chk("R7 vis locked after first normal write", reg_rdata, 8'h10);
   endtask

   task automatic t_single_chip();
      do_reset(1'b1, 1'b0);
      wr_reg(8'hF3);
      chk("R5 R9 single write masks flags", reg_rdata, 8'h13);
      chk("R8 single vis forced off", {7'd0, read_vis}, 8'h00);
      wr_reg(8'h0C);
      chk("R7 second normal write keeps vis", reg_rdata, 8'h1C);
   endtask

   task automatic t_expanded();
      do_reset(1'b1, 1'b1);
      wr_reg(8'h3F);
      chk("R9 expanded write", reg_rdata, 8'h3F);
      chk("R8 expanded vis on", {7'd0, read_vis}, 8'h01);
      wr_reg(8'h05);
      chk("R5 R7 expanded flags and vis hold", reg_rdata, 8'h35);
      chk("R8 expanded vis stays", {7'd0, read_vis}, 8'h01);
   endtask

   task automatic t_special_vis();
      do_reset(1'b0, 1'b1);
      wr_reg(8'h75);
      chk("R7 special vis set", reg_rdata, 8'h75);
      chk("R8 test vis on", {7'd0, read_vis}, 8'h01);
      wr_reg(8'h65);
      chk("R7 special vis cleared", reg_rdata, 8'h65);
      wr_reg(8'h75);
      chk("R7 special vis set again", reg_rdata, 8'h75);
      wr_reg(8'h55);
      chk("R2 switch to bootstrap", {6'd0, op_mode}, 8'h02);
      chk("R8 bootstrap vis off", {7'd0, read_vis}, 8'h00);
   endtask

   task automatic t_no_write();
      do_reset(1'b0, 1'b1);
      reg_sel = 1'b1; reg_wr = 1'b0; reg_wdata = 8'h9A;
      @(negedge clk);
      chk("R10 select without strobe", reg_rdata, 8'h65);
      reg_sel = 1'b0; reg_wr = 1'b1;
      @(negedge clk);
      chk("R10 strobe without select", reg_rdata, 8'h65);
      reg_wr = 1'b0;
   endtask

   initial begin
      t_reset_images();
      t_boot_rom();
      t_leave_special();
      t_single_chip();
      t_expanded();
      t_special_vis();
      t_no_write();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog all-R actual=timeout expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule